// File: doc/BRIEF.md
# Mini UART Register Front End

This block is the register face of a small UART. A host reaches it through a 32-bit, word-wide register port with byte-granular offsets. Received bytes arrive on a valid/ready byte stream and wait in an eight-entry FIFO until software reads them. A byte written to the data register leaves on a transmit byte stream as a single-cycle valid pulse. Serial framing and bit timing sit outside this block.

The block keeps an interrupt enable pair (transmit and receive) and drives one level-sensitive interrupt line. The transmit side is modelled as always drained, so an enabled transmit interrupt stays asserted. The receive interrupt asserts while the FIFO holds data. Status words report FIFO occupancy, and the interrupt identification word gives receive data priority. The line and modem configuration, scratch and rate registers are decoded but hold nothing. They read as zero, and writes to them are dropped.

Top module: `mini_uart_regs`

## Requirements
- R1: After reset the FIFO is empty, both interrupt enables are 0, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: The receive FIFO holds 8 bytes. A byte is taken when `rx_valid` and `rx_ready` are both high, and `rx_ready` is low while 8 bytes are held.
- R3: A read of offset 0x40 returns the oldest held byte in bits 7:0 and removes it, so bytes come out in arrival order.
- R4: A read of offset 0x40 with the FIFO empty returns the byte stored in the slot at the read position and changes no occupancy.
- R5: A write to offset 0x40 drives `wdata[7:0]` on `tx_data`, with `tx_valid` high for exactly the one cycle that follows the write.
- R6: Offset 0x44 keeps written bits 1:0 (bit 0 transmit enable, bit 1 receive enable) and reads as 0xC0 ORed with them.
- R7: `irq` is registered. It is high when the transmit enable is set, or when the receive enable is set and the FIFO is not empty. It follows a change one cycle after the state that causes it.
- R8: Offset 0x48 reads 0xC0 plus 0x04 when the FIFO holds data, otherwise 0x02, plus bit 0 set when no interrupt is pending. This value is registered like `irq`.
- R9: A write to offset 0x48 with bit 1 set empties the FIFO and holds `rx_ready` low in that cycle. With bit 1 clear, the write does nothing.
- R10: Offset 0x54 reads 0x60, plus bit 0 when the FIFO holds data.
- R11: Offset 0x64 reads 0x30E. When the FIFO holds data, bit 0 is also set and bits 19:16 carry the FIFO count.
- R12: Offset 0x04 reads 1, offset 0x60 reads 3, and offset 0x00 reads 1 in bit 0 exactly when `irq` is high.
- R13: Offsets 0x4C, 0x50, 0x58, 0x5C and 0x68, and every offset not named above, read 0. Writes to them, and to the read-only offsets, change nothing and send nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Outgoing byte pulse |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The receive path is tested with a single byte, with a burst of four, and with a fill to eight plus a refused ninth byte. The first case separates empty from non-empty status. The burst checks ordering and the count field. The fill checks back-pressure and pointer wrap. The empty-FIFO read runs after the pointers have wrapped, so it separates a stale-slot read from a reset value. Interrupt identification is read with only transmit enabled, with only receive enabled, and with both enabled while data is held, which shows the receive priority. Flush writes are made with bit 1 set and with it clear, and with a byte offered in the same cycle, so that a flush can be told apart from a plain write.

// File: rtl/mu_pkg.sv
package mu_pkg;

    localparam logic [7:0] OFS_IRQ_SUM    = 8'h00;
    localparam logic [7:0] OFS_EN         = 8'h04;
    localparam logic [7:0] OFS_DATA       = 8'h40;
    localparam logic [7:0] OFS_INT_EN     = 8'h44;
    localparam logic [7:0] OFS_INT_ID     = 8'h48;
    localparam logic [7:0] OFS_LINE_CFG   = 8'h4C;
    localparam logic [7:0] OFS_MODEM_CFG  = 8'h50;
    localparam logic [7:0] OFS_LINE_STAT  = 8'h54;
    localparam logic [7:0] OFS_MODEM_STAT = 8'h58;
    localparam logic [7:0] OFS_SPARE      = 8'h5C;
    localparam logic [7:0] OFS_CTRL       = 8'h60;
    localparam logic [7:0] OFS_XSTAT      = 8'h64;
    localparam logic [7:0] OFS_RATE       = 8'h68;

    localparam int IE_TX_BIT    = 0;
    localparam int IE_RX_BIT    = 1;
    localparam int FLUSH_BIT    = 1;
    localparam int XSTAT_CNT_LSB = 16;

    localparam logic [7:0]  ID_BASE      = 8'hC0;
    localparam logic [7:0]  ID_RX_CODE   = 8'h04;
    localparam logic [7:0]  ID_TX_CODE   = 8'h02;
    localparam logic [7:0]  ID_IDLE_BIT  = 8'h01;
    localparam logic [31:0] LSTAT_BASE   = 32'h0000_0060;
    localparam logic [31:0] XSTAT_BASE   = 32'h0000_030E;
    localparam logic [31:0] EN_VALUE     = 32'h0000_0001;
    localparam logic [31:0] CTRL_VALUE   = 32'h0000_0003;

    typedef enum logic [3:0] {
        K_NONE,
        K_IRQ_SUM,
        K_EN,
        K_DATA,
        K_INT_EN,
        K_INT_ID,
        K_LINE_STAT,
        K_CTRL,
        K_XSTAT,
        K_HOLDLESS
    } reg_kind_e;

    typedef struct packed {
        logic [1:0] pend;
        logic [7:0] id;
    } irq_state_t;

endpackage

// File: rtl/mu_addr_decode.sv
module mu_addr_decode
    import mu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind
);

    always_comb begin
        case (addr)
            ADDR_W'(OFS_IRQ_SUM):    kind = K_IRQ_SUM;
            ADDR_W'(OFS_EN):         kind = K_EN;
            ADDR_W'(OFS_DATA):       kind = K_DATA;
            ADDR_W'(OFS_INT_EN):     kind = K_INT_EN;
            ADDR_W'(OFS_INT_ID):     kind = K_INT_ID;
            ADDR_W'(OFS_LINE_STAT):  kind = K_LINE_STAT;
            ADDR_W'(OFS_CTRL):       kind = K_CTRL;
            ADDR_W'(OFS_XSTAT):      kind = K_XSTAT;
            ADDR_W'(OFS_LINE_CFG),
            ADDR_W'(OFS_MODEM_CFG),
            ADDR_W'(OFS_MODEM_STAT),
            ADDR_W'(OFS_SPARE),
            ADDR_W'(OFS_RATE):       kind = K_HOLDLESS;
            default:                 kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/mu_rx_fifo.sv
module mu_rx_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
    endfunction

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rd];

    always_comb begin
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d.wr  = st_q.rd;
            st_d.cnt = '0;
        end else begin
            if (do_push) st_d.wr = step(st_q.wr);
            if (do_pop)  st_d.rd = step(st_q.rd);
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

endmodule

// File: rtl/mu_irq_gen.sv
module mu_irq_gen
    import mu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ie,
    input  logic       rx_has_data,
    output logic       irq,
    output logic [7:0] id_byte
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d.pend[IE_RX_BIT] = ie[IE_RX_BIT] && rx_has_data;
        st_d.pend[IE_TX_BIT] = ie[IE_TX_BIT];
        st_d.id = ID_BASE | (rx_has_data ? ID_RX_CODE : ID_TX_CODE);
        if (st_d.pend == '0) st_d.id = st_d.id | ID_IDLE_BIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.id   <= ID_BASE | ID_TX_CODE | ID_IDLE_BIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = |st_q.pend;
    assign id_byte = st_q.id;

endmodule

// File: rtl/mini_uart_regs.sv
module mini_uart_regs
    import mu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);

    typedef struct packed {
        logic [1:0]        ie;
        logic              tx_vld;
        logic [BYTE_W-1:0] tx_byte;
    } front_state_t;

    front_state_t st_d, st_q;
    reg_kind_e         kind;
    logic              wr_acc, rd_acc;
    logic              flush_req, pop_req, push_req;
    logic [BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, fifo_empty;
    logic [7:0]        id_byte;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:BYTE_W];

    mu_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .kind (kind)
    );

    assign wr_acc    = bus_sel && bus_wr;
    assign rd_acc    = bus_sel && !bus_wr;
    assign flush_req = wr_acc && (kind == K_INT_ID) && bus_wdata[FLUSH_BIT];
    assign pop_req   = rd_acc && (kind == K_DATA);
    assign rx_ready  = !fifo_full && !flush_req;
    assign push_req  = rx_valid && rx_ready;

    mu_rx_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .push_data (rx_data),
        .pop       (pop_req),
        .flush     (flush_req),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    mu_irq_gen u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ie          (st_q.ie),
        .rx_has_data (!fifo_empty),
        .irq         (irq),
        .id_byte     (id_byte)
    );

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = 1'b0;
        if (wr_acc && (kind == K_INT_EN)) begin
            st_d.ie = bus_wdata[1:0];
        end
        if (wr_acc && (kind == K_DATA)) begin
            st_d.tx_vld  = 1'b1;
            st_d.tx_byte = bus_wdata[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.tx_vld;
    assign tx_data  = st_q.tx_byte;

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            case (kind)
                K_IRQ_SUM:   bus_rdata = BUS_W'(irq);
                K_EN:        bus_rdata = BUS_W'(EN_VALUE);
                K_DATA:      bus_rdata = BUS_W'(fifo_head);
                K_INT_EN:    bus_rdata = BUS_W'(ID_BASE) | BUS_W'(st_q.ie);
                K_INT_ID:    bus_rdata = BUS_W'(id_byte);
                K_LINE_STAT: bus_rdata = BUS_W'(LSTAT_BASE) | BUS_W'(!fifo_empty);
                K_CTRL:      bus_rdata = BUS_W'(CTRL_VALUE);
                K_XSTAT: begin
                    bus_rdata = BUS_W'(XSTAT_BASE);
                    if (!fifo_empty) begin
                        bus_rdata = bus_rdata | BUS_W'(1)
                                  | (BUS_W'(fifo_cnt) << XSTAT_CNT_LSB);
                    end
                end
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mu_checker.sv
module mu_checker
    import mu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_data,
    input logic              irq,
    input logic [CNT_W-1:0]  fifo_cnt
);

    logic data_wr, flush_wr, ie_clear_wr, unused_chk;
    assign data_wr     = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
    assign flush_wr    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_INT_ID))
                         && bus_wdata[FLUSH_BIT];
    assign ie_clear_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_INT_EN))
                         && (bus_wdata[1:0] == 2'b00);
    assign unused_chk  = ^bus_wdata[BUS_W-1:BYTE_W];

    // R2
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    // R2
    a_r2_full_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CNT_W'(DEPTH)) |-> !rx_ready);

    // R4
    a_r4_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0 && !(rx_valid && rx_ready)) |=> (fifo_cnt == '0));

    // R5
    a_r5_tx_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));

    // R5
    a_r5_tx_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> !tx_valid);

    // R9
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> (fifo_cnt == '0));

    // R9
    a_r9_flush_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |-> !rx_ready);

    // R7
    a_r7_irq_drops_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clear_wr |=> (!(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_INT_EN)) |=> !irq));

endmodule

bind mini_uart_regs mu_checker #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .BYTE_W (BYTE_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .irq       (irq),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/mini_uart_regs_tb.sv
module mini_uart_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] rx_exp[$];
    logic [7:0] tx_exp[$];

    always #10 clk = ~clk;

    mini_uart_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a == 8'h40) tx_exp.push_back(d[7:0]);
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        bus_read(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic push_rx(input logic [7:0] b);
        bit took;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        #1 took = rx_ready;
        @(posedge clk);
        #1 rx_valid = 1'b0;
        if (took) rx_exp.push_back(b);
    endtask

    task automatic pop_chk(input string tag);
        logic [31:0] v;
        logic [7:0]  e;
        bus_read(8'h40, v);
        e = (rx_exp.size() != 0) ? rx_exp.pop_front() : 8'h00;
        chk(v == {24'h0, e}, tag, v, {24'h0, e});
    endtask

    // Monitor: every transmit pulse must match the oldest expected byte (R5)
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (tx_exp.size() == 0) begin
                chk(1'b0, "R5 unexpected tx pulse", {24'h0, tx_data}, 32'h0);
            end else begin
                logic [7:0] e;
                e = tx_exp.pop_front();
                chk(tx_data == e, "R5 tx byte", {24'h0, tx_data}, {24'h0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        #1;
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
        chk(tx_valid == 1'b0, "R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        chk(rx_ready == 1'b1, "R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        rd_chk(8'h44, 32'hC0, "R1 enables clear");
        rd_chk(8'h64, 32'h30E, "R1 fifo empty");

        // R12 constant registers
        rd_chk(8'h04, 32'h1, "R12 enables word");
        rd_chk(8'h60, 32'h3, "R12 control word");
        rd_chk(8'h00, 32'h0, "R12 summary idle");

        // R6 enable register
        bus_write(8'h44, 32'hFF);
        rd_chk(8'h44, 32'hC3, "R6 enable keeps two bits");
        bus_write(8'h44, 32'h01);
        rd_chk(8'h44, 32'hC1, "R6 tx only");

        // R7 / R8 transmit interrupt alone
        idle(2);
        chk(irq == 1'b1, "R7 tx enable raises irq", {31'h0, irq}, 32'h1);
        rd_chk(8'h00, 32'h1, "R12 summary pending");
        rd_chk(8'h48, 32'hC2, "R8 id tx pending");

        bus_write(8'h44, 32'h00);
        idle(2);
        chk(irq == 1'b0, "R7 disable drops irq", {31'h0, irq}, 32'h0);
        rd_chk(8'h48, 32'hC3, "R8 id nothing pending");

        // R7 / R8 receive interrupt
        bus_write(8'h44, 32'h02);
        idle(2);
        chk(irq == 1'b0, "R7 rx enable with empty fifo", {31'h0, irq}, 32'h0);
        push_rx(8'h11);
        idle(2);
        chk(irq == 1'b1, "R7 rx data raises irq", {31'h0, irq}, 32'h1);
        rd_chk(8'h48, 32'hC4, "R8 id rx pending");
        rd_chk(8'h54, 32'h61, "R10 data ready bit");
        rd_chk(8'h64, 32'h1030F, "R11 count one");

        // R8 receive priority with both enabled
        bus_write(8'h44, 32'h03);
        idle(2);
        rd_chk(8'h48, 32'hC4, "R8 rx outranks tx");
        bus_write(8'h44, 32'h02);

        // R3 burst ordering
        push_rx(8'h22);
        push_rx(8'h33);
        push_rx(8'h44);
        rd_chk(8'h64, 32'h4030F, "R11 count four");
        for (int i = 0; i < 4; i++) pop_chk("R3 arrival order");
        idle(2);
        chk(irq == 1'b0, "R7 drained fifo drops irq", {31'h0, irq}, 32'h0);
        rd_chk(8'h48, 32'hC3, "R8 id after drain");
        rd_chk(8'h54, 32'h60, "R10 no data");

        // R2 fill to eight, wrap, refuse ninth
        for (int i = 0; i < 8; i++) push_rx(8'hF0 + 8'(i));
        rd_chk(8'h64, 32'h8030F, "R11 count eight");
        #1 chk(rx_ready == 1'b0, "R2 full backpressure", {31'h0, rx_ready}, 32'h0);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hEE;
        idle(3);
        rx_valid = 1'b0;
        rd_chk(8'h64, 32'h8030F, "R2 ninth byte refused");
        for (int i = 0; i < 8; i++) pop_chk("R2 R3 wrapped order");
        rd_chk(8'h64, 32'h30E, "R11 empty after drain");

        // R4 read while empty: slot at read position holds the first byte of the fill
        rd_chk(8'h40, 32'hF0, "R4 stale head");
        rd_chk(8'h64, 32'h30E, "R4 no pointer change");
        push_rx(8'h5A);
        pop_chk("R4 next byte after empty read");

        // R9 flush
        push_rx(8'h61);
        push_rx(8'h62);
        push_rx(8'h63);
        bus_write(8'h48, 32'h04);
        rd_chk(8'h64, 32'h3030F, "R9 bit1 clear no flush");
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h02;
        rx_valid = 1'b1; rx_data = 8'h77;
        #1 chk(rx_ready == 1'b0, "R9 ready low during flush", {31'h0, rx_ready}, 32'h0);
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
        rx_exp.delete();
        rd_chk(8'h64, 32'h30E, "R9 flush empties");
        rd_chk(8'h54, 32'h60, "R9 line status after flush");

        // R5 transmit: single and back to back
        bus_write(8'h40, 32'h1A5);
        idle(1);
        bus_write(8'h40, 32'h3C);
        bus_write(8'h40, 32'hC3);
        idle(3);
        chk(tx_exp.size() == 0, "R5 all bytes sent", tx_exp.size(), 32'h0);

        // R13 holdless, read-only and unmapped offsets
        bus_write(8'h44, 32'h01);
        bus_write(8'h4C, 32'hFF);
        bus_write(8'h50, 32'hFF);
        bus_write(8'h58, 32'hFF);
        bus_write(8'h5C, 32'hFF);
        bus_write(8'h68, 32'hFF);
        bus_write(8'h80, 32'hFF);
        bus_write(8'h64, 32'hFF);
        bus_write(8'h04, 32'h00);
        rd_chk(8'h4C, 32'h0, "R13 line cfg reads zero");
        rd_chk(8'h50, 32'h0, "R13 modem cfg reads zero");
        rd_chk(8'h58, 32'h0, "R13 modem stat reads zero");
        rd_chk(8'h5C, 32'h0, "R13 spare reads zero");
        rd_chk(8'h68, 32'h0, "R13 rate reads zero");
        rd_chk(8'h80, 32'h0, "R13 unmapped reads zero");
        rd_chk(8'h44, 32'hC1, "R13 enables untouched");
        rd_chk(8'h04, 32'h1, "R13 enables word untouched");
        rd_chk(8'h64, 32'h30E, "R13 fifo untouched");
        idle(3);
        chk(tx_exp.size() == 0, "R13 no tx from other offsets", tx_exp.size(), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule